// File: doc/BRIEF.md
# Remote Interrupt Relay with Read-to-Clear Status

This block sits in the transmit end of a serial link. It passes an active-low interrupt from a device on the far side of the link to an active-low interrupt line that a local host controller watches. The remote level first goes through a synchronizer. Its falling edge then sets a sticky status flag. While that flag is set and the interrupt path is enabled, the block pulls its local output low.

The host learns the cause by reading a status register over a plain synchronous register port, and that read clears the flag. The host must also clear the source on the far side separately. A remote line that stays low does not raise a second interrupt. The block re-arms only on the next falling edge of the remote line.

Top module: `irq_relay`

## Requirements
- R1: After reset the local output `irq_n` is high, the control register at address 0xC6 reads 0x00 and the status flag is clear.
- R2: The control register at address 0xC6 is writable and readable. Bit 0 is the global enable and bit 5 is the source enable. Only those two bits are stored, and every other bit reads 0.
- R3: When both enables are 1, a falling edge on `remote_irq_n` sets the flag. `irq_n` goes low on the third rising clock edge after the input falls: two edges to synchronize it and one to latch it.
- R4: While either enable bit is 0, falling edges are not latched and `irq_n` stays high.
- R5: The flag is sticky. It stays set, and `irq_n` stays low, after `remote_irq_n` returns high, until the host reads the status register.
- R6: A read at address 0xC7 returns the flag in bit 0 and the synchronized remote level in bit 1, with the other bits 0. `rd_data` holds this value in the cycle after `rd_en`. The read clears the flag, so `irq_n` is high after that clock edge.
- R7: A remote level that stays low after a clear never sets the flag again. Only a new falling edge does.
- R8: If a detected falling edge and a status read fall in the same cycle, the set wins. The flag stays set and `irq_n` stays low.
- R9: Clearing an enable while the flag is set drives `irq_n` high without clearing the flag. Setting the enable again drives `irq_n` low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remote_irq_n | input | 1 | Active-low interrupt level from the far side, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
A flag that is wrongly set or left uncleared shows at once on `irq_n`. It also shows in bit 0 of the next status read, one cycle after the read strobe. A wrong synchronizer or edge detector shifts the fall of `irq_n` away from the third edge after the input falls, or lets a held-low level fire again. A broken set-versus-clear priority shows at the port in the cycle after a read that coincides with an edge. The bench therefore pins every check to an exact clock edge.

// File: rtl/irq_relay_pkg.sv
package irq_relay_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 8;
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'hC6;
    localparam logic [ADDR_W-1:0] STAT_ADDR = 8'hC7;

    localparam int GLB_EN_BIT = 0;
    localparam int SRC_EN_BIT = 5;
    localparam int FLAG_BIT   = 0;
    localparam int LEVEL_BIT  = 1;

    typedef struct packed {
        logic src_en;
        logic glb_en;
    } ctrl_t;

    typedef struct packed {
        logic level;
        logic flag;
    } stat_t;

    function automatic ctrl_t ctrl_from_byte(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.glb_en = b[GLB_EN_BIT];
        c.src_en = b[SRC_EN_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [DATA_W-1:0] b;
        b = '0;
        b[GLB_EN_BIT] = c.glb_en;
        b[SRC_EN_BIT] = c.src_en;
        return b;
    endfunction

    function automatic logic [DATA_W-1:0] stat_to_byte(input stat_t s);
        logic [DATA_W-1:0] b;
        b = '0;
        b[FLAG_BIT]  = s.flag;
        b[LEVEL_BIT] = s.level;
        return b;
    endfunction

    function automatic logic path_enabled(input ctrl_t c);
        return c.glb_en & c.src_en;
    endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic level_n,
    output logic fall
);
    logic [DEPTH-1:0] chain_q;
    logic             prev_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[DEPTH-2:0], async_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[DEPTH-1];
    end

    assign level_n = chain_q[DEPTH-1];
    assign fall    = prev_q & ~chain_q[DEPTH-1];
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_relay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  stat_t             stat,
    output ctrl_t             ctrl,
    output logic              rd_clr,
    output logic [DATA_W-1:0] rd_data
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst)                            ctrl_q <= '0;
        else if (wr_en && addr == CTRL_ADDR) ctrl_q <= ctrl_from_byte(wr_data);
    end

    always_comb begin
        unique case (addr)
            CTRL_ADDR: rd_mux = ctrl_to_byte(ctrl_q);
            STAT_ADDR: rd_mux = stat_to_byte(stat);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= rd_mux;
    end

    assign ctrl    = ctrl_q;
    assign rd_clr  = rd_en && (addr == STAT_ADDR);
    assign rd_data = rd_q;
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq_n
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (set) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag  = flag_q;
    assign irq_n = ~(flag_q & en);
endmodule

// File: rtl/irq_relay.sv
module irq_relay
    import irq_relay_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              remote_irq_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic  level_w;
    logic  fall_w;
    logic  en_w;
    logic  rd_clr_w;
    logic  flag_w;
    ctrl_t ctrl_w;
    stat_t stat_w;

    irq_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (remote_irq_n),
        .level_n (level_w),
        .fall    (fall_w)
    );

    assign stat_w.flag  = flag_w;
    assign stat_w.level = level_w;

    irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .stat    (stat_w),
        .ctrl    (ctrl_w),
        .rd_clr  (rd_clr_w),
        .rd_data (rd_data)
    );

    assign en_w = path_enabled(ctrl_w);

    irq_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set   (fall_w & en_w),
        .clr   (rd_clr_w),
        .en    (en_w),
        .flag  (flag_w),
        .irq_n (irq_n)
    );
endmodule

// File: rtl/irq_relay_chk.sv
module irq_relay_chk (
    input logic clk,
    input logic rst,
    input logic fall,
    input logic en,
    input logic rd_clr,
    input logic wr_en,
    input logic irq_n
);
    // R4
    mask_high_chk: assert property (@(posedge clk) disable iff (rst)
        !en |-> irq_n);

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !fall && !wr_en) |=> irq_n);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && en && rd_clr && !wr_en) |=> !irq_n);

    // R3
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (fall && en && !wr_en) |=> !irq_n);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n && !rd_clr && !wr_en) |=> !irq_n);

    // R7
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_n && !fall && !wr_en) |=> irq_n);
endmodule

bind irq_relay irq_relay_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .fall   (fall_w),
    .en     (en_w),
    .rd_clr (rd_clr_w),
    .wr_en  (wr_en),
    .irq_n  (irq_n)
);

// File: tb/irq_relay_bench.sv
module irq_relay_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'hC6;
    localparam logic [7:0] A_STAT = 8'hC7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       remote_irq_n = 1'b1;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    typedef struct {
        bit         is_rd;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_relay u_irq_relay (
        .clk          (clk),
        .rst          (rst),
        .remote_irq_n (remote_irq_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .irq_n        (irq_n)
    );

    // monitor: pops expected items and compares with observed outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = q.pop_front();
                act = it.is_rd ? rd_data : {7'b0, irq_n};
                compared++;
                if (act !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        it.is_rd = 1'b0; it.exp = {7'b0, e}; it.tag = tag;
        q.push_back(it);
        -> chk_ev;
    endtask

    task automatic expect_rd(input logic [7:0] e, input string tag);
        item_t it;
        it.is_rd = 1'b1; it.exp = e; it.tag = tag;
        q.push_back(it);
        -> chk_ev;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        cycles(1);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a);
        rd_en = 1'b1; addr = a;
        cycles(1);
        rd_en = 1'b0;
    endtask

    task automatic remote_high_settle();
        remote_irq_n = 1'b1;
        cycles(3);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cycles(3);
        rst = 1'b0;
        cycles(1);

        // R1 reset state
        expect_irq(1'b1, "R1 irq_n after reset");
        reg_read(A_CTRL);
        expect_rd(8'h00, "R1 ctrl after reset");
        reg_read(A_STAT);
        expect_rd(8'h02, "R1 status after reset");

        // R4 global enable only: edge ignored
        reg_write(A_CTRL, 8'h01);
        remote_irq_n = 1'b0;
        cycles(5);
        expect_irq(1'b1, "R4 glb only irq_n");
        reg_read(A_STAT);
        expect_rd(8'h00, "R4 glb only flag");
        remote_high_settle();

        // R4 source enable only: edge ignored
        reg_write(A_CTRL, 8'h20);
        remote_irq_n = 1'b0;
        cycles(5);
        expect_irq(1'b1, "R4 src only irq_n");
        reg_read(A_STAT);
        expect_rd(8'h00, "R4 src only flag");
        remote_high_settle();

        // R2 only enable bits stored
        reg_write(A_CTRL, 8'hFF);
        reg_read(A_CTRL);
        expect_rd(8'h21, "R2 ctrl readback");

        // R3 latency: low on third edge
        remote_irq_n = 1'b0;
        cycles(2);
        expect_irq(1'b1, "R3 irq_n after two edges");
        cycles(1);
        expect_irq(1'b0, "R3 irq_n after three edges");

        // R6 read returns flag and level, clears
        reg_read(A_STAT);
        expect_rd(8'h01, "R6 status flag set level low");
        expect_irq(1'b1, "R6 irq_n released by read");

        // R7 held low does not retrigger
        cycles(10);
        expect_irq(1'b1, "R7 held low no retrigger");
        reg_read(A_STAT);
        expect_rd(8'h00, "R7 flag stays clear");

        // R7 new edge retriggers; R5 sticky after remote release
        remote_high_settle();
        remote_irq_n = 1'b0;
        cycles(3);
        expect_irq(1'b0, "R7 new edge retriggers");
        remote_irq_n = 1'b1;
        cycles(4);
        expect_irq(1'b0, "R5 sticky after remote release");
        reg_read(A_STAT);
        expect_rd(8'h03, "R6 status flag set level high");
        expect_irq(1'b1, "R5 cleared by read");

        // R9 masking keeps flag
        remote_irq_n = 1'b0;
        cycles(3);
        expect_irq(1'b0, "R9 flag set");
        reg_write(A_CTRL, 8'h01);
        expect_irq(1'b1, "R9 masked irq_n high");
        reg_write(A_CTRL, 8'h21);
        expect_irq(1'b0, "R9 unmasked irq_n low");
        reg_read(A_STAT);
        expect_rd(8'h01, "R9 flag survived mask");
        remote_high_settle();

        // R8 set wins over coincident read
        remote_irq_n = 1'b0;
        cycles(2);
        reg_read(A_STAT);
        expect_rd(8'h00, "R8 coincident read data");
        expect_irq(1'b0, "R8 set wins irq_n");
        reg_read(A_STAT);
        expect_rd(8'h01, "R8 flag kept");
        expect_irq(1'b1, "R8 later read clears");

        cycles(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule